// File: doc/BRIEF.md
# Register-Window Access Bridge

This block sits between a PCIe transaction layer and the control/status registers of user logic. Host accesses that land in the register window, base address region 2, go straight to a memory-mapped master port without passing through the DMA engine. The input is an already decoded request: the hit region, the requester's function identity, a byte offset, a byte length, a beat count, write data and a tag. Each qualifying request becomes exactly one 64-bit, single-beat read or write on the master port. The master port uses waitrequest and readdatavalid handshakes.

The user-side address carries the function identity above the byte offset. From the top bit down it is a virtual-function flag, the physical function number, the virtual function number and the offset. The function fields are `$clog2` of the configured function counts wide, so no address wire goes unused. Reads are non-posted and strictly one at a time: the block stalls its input until the data returns, then sends a completion with the original tag. Writes are posted. A request that is malformed but still targets the register window is never issued on the user side. A malformed read gets an unsupported-request completion. A malformed write is dropped and flagged with a one-cycle error pulse.

Top module: `regbar_bridge`

## Requirements
- R1: Only requests with `req_bar` equal to 2 can reach the user port. Any other region index is consumed with no user access, no completion and no error pulse.
- R2: The user address is {`req_vf_active`, `req_pf`, vf field, `req_addr`}. Its width is 1 + $clog2(NUM_PF) + $clog2(NUM_VF) + OFS_W.
- R3: When `req_vf_active` is 0, the vf field of the user address is zero whatever `req_vf` carries. When it is 1, the field is `req_vf`.
- R4: Every user access moves one 64-bit word: `usr_burstcount` is 1, `usr_byteenable` is all ones, and read and write are never asserted together.
- R5: A region-2 request qualifies only when `req_addr[2:0]` is 0, `req_len` is 8 and `req_beats` is 1. Otherwise nothing is issued on the user port.
- R6: A non-qualifying region-2 read produces one completion cycle with status 3'b001 (unsupported request), the request's tag and data zero.
- R7: A non-qualifying region-2 write produces a one-cycle `wr_err` pulse and no completion.
- R8: While `usr_waitrequest` is high, the asserted command, address and write data stay unchanged. The access counts as taken in the first cycle with `usr_waitrequest` low, and the command drops in the next cycle.
- R9: From a read's issue until `usr_readdatavalid`, `req_ready` is low. In the cycle after `usr_readdatavalid`, the completion appears with status 3'b000, the request's tag and `usr_readdata`.
- R10: A write produces no completion, and `req_ready` is high in the cycle after the user port takes it.
- R11: After reset, `req_ready` is high, and `usr_read`, `usr_write`, `cpl_valid` and `wr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bar | input | 3 | Region index hit by the request |
| req_vf_active | input | 1 | Request targets a virtual function |
| req_pf | input | $clog2(NUM_PF) | Physical function number |
| req_vf | input | $clog2(NUM_VF) | Virtual function number |
| req_addr | input | OFS_W | Byte offset inside the region |
| req_len | input | LEN_W | Request length in bytes |
| req_beats | input | BC_W | Requested beat count |
| req_wdata | input | 64 | Write data |
| req_tag | input | TAG_W | Request tag |
| usr_read | output | 1 | User read command |
| usr_write | output | 1 | User write command |
| usr_address | output | 1+$clog2(NUM_PF)+$clog2(NUM_VF)+OFS_W | Packed user address |
| usr_writedata | output | 64 | User write data |
| usr_byteenable | output | 8 | Byte enables |
| usr_burstcount | output | BC_W | Beat count, always 1 |
| usr_waitrequest | input | 1 | User port stall |
| usr_readdata | input | 64 | User read data |
| usr_readdatavalid | input | 1 | Read data valid |
| cpl_valid | output | 1 | Completion present (one cycle) |
| cpl_tag | output | TAG_W | Completion tag |
| cpl_status | output | 3 | 3'b000 success, 3'b001 unsupported request |
| cpl_data | output | 64 | Completion data |
| wr_err | output | 1 | Dropped malformed write pulse |

## Verification
The bench writes and then reads back every physical function, both vf_active states and every vf number, with an offset that is different for each combination. An address packer that shifted a field, or that let the vf number through for a physical function, would miss the expected address and the read-back data pattern. Each of the three qualification terms (misaligned offsets 1 to 7, lengths 0, 4 and 16, beat counts 0 and 2) is violated on its own, for reads and for writes, together with every other region index. A design that issued such a request would change the user-side access counts. One that confused the read and write error paths would produce the wrong completion count or pulse count. The model slave varies both its waitrequest stall and its read latency, so a controller that dropped its command early or released the input before the data returned would be caught.

// File: rtl/regbar_pkg.sv
package regbar_pkg;

    localparam int unsigned DATA_W     = 64;
    localparam int unsigned BE_W       = DATA_W / 8;
    localparam int unsigned WORD_BYTES = DATA_W / 8;
    localparam int unsigned BAR_W      = 3;
    localparam int unsigned REG_BAR    = 2;
    localparam int unsigned STAT_W     = 3;

    localparam logic [STAT_W-1:0] CPL_SC = 3'b000;
    localparam logic [STAT_W-1:0] CPL_UR = 3'b001;

    typedef enum logic [1:0] {
        CLS_IGNORE,
        CLS_BAD,
        CLS_GOOD
    } req_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_RWAIT
    } bridge_state_e;

    function automatic logic word_aligned(input logic [2:0] low_bits);
        return low_bits == 3'b000;
    endfunction

endpackage

// File: rtl/regbar_screen.sv
module regbar_screen
    import regbar_pkg::*;
#(
    parameter int unsigned NUM_PF = 4,
    parameter int unsigned NUM_VF = 8,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned BC_W   = 4,
    localparam int unsigned PF_W  = $clog2(NUM_PF),
    localparam int unsigned VF_W  = $clog2(NUM_VF),
    localparam int unsigned UA_W  = 1 + PF_W + VF_W + OFS_W
) (
    input  logic [BAR_W-1:0] bar,
    input  logic             vf_active,
    input  logic [PF_W-1:0]  pf,
    input  logic [VF_W-1:0]  vf,
    input  logic [OFS_W-1:0] offset,
    input  logic [LEN_W-1:0] len,
    input  logic [BC_W-1:0]  beats,
    output req_class_e       cls,
    output logic [UA_W-1:0]  uaddr
);

    logic            shape_ok;
    logic [VF_W-1:0] vf_field;

    assign shape_ok = word_aligned(offset[2:0])
                   && (len == LEN_W'(WORD_BYTES))
                   && (beats == BC_W'(1));

    always_comb begin
        if (bar != BAR_W'(REG_BAR)) begin
            cls = CLS_IGNORE;
        end else if (shape_ok) begin
            cls = CLS_GOOD;
        end else begin
            cls = CLS_BAD;
        end
    end

    assign vf_field = vf_active ? vf : '0;
    assign uaddr    = {vf_active, pf, vf_field, offset};

endmodule

// File: rtl/regbar_ctrl.sv
module regbar_ctrl
    import regbar_pkg::*;
#(
    parameter int unsigned UA_W  = 18,
    parameter int unsigned TAG_W = 6,
    parameter int unsigned BC_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  req_class_e        cls,
    input  logic [UA_W-1:0]   uaddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TAG_W-1:0]  tag,
    output logic              usr_read,
    output logic              usr_write,
    output logic [UA_W-1:0]   usr_address,
    output logic [DATA_W-1:0] usr_writedata,
    output logic [BE_W-1:0]   usr_byteenable,
    output logic [BC_W-1:0]   usr_burstcount,
    input  logic              usr_waitrequest,
    input  logic [DATA_W-1:0] usr_readdata,
    input  logic              usr_readdatavalid,
    output logic              cpl_valid,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [STAT_W-1:0] cpl_status,
    output logic [DATA_W-1:0] cpl_data,
    output logic              wr_err
);

    typedef struct packed {
        logic [UA_W-1:0]   addr;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } held_cmd_t;

    bridge_state_e state_q;
    held_cmd_t     cmd_q;
    logic          take;

    assign req_ready = (state_q == ST_IDLE);
    assign take      = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cmd_q      <= '0;
            cpl_valid  <= 1'b0;
            cpl_tag    <= '0;
            cpl_status <= CPL_SC;
            cpl_data   <= '0;
            wr_err     <= 1'b0;
        end else begin
            cpl_valid <= 1'b0;
            wr_err    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        unique case (cls)
                            CLS_GOOD: begin
                                cmd_q   <= '{addr: uaddr, data: wdata, tag: tag};
                                state_q <= req_write ? ST_WR : ST_RD;
                            end
                            CLS_BAD: begin
                                if (req_write) begin
                                    wr_err <= 1'b1;
                                end else begin
                                    cpl_valid  <= 1'b1;
                                    cpl_tag    <= tag;
                                    cpl_status <= CPL_UR;
                                    cpl_data   <= '0;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WR: begin
                    if (!usr_waitrequest) state_q <= ST_IDLE;
                end
                ST_RD: begin
                    if (!usr_waitrequest) state_q <= ST_RWAIT;
                end
                ST_RWAIT: begin
                    if (usr_readdatavalid) begin
                        cpl_valid  <= 1'b1;
                        cpl_tag    <= cmd_q.tag;
                        cpl_status <= CPL_SC;
                        cpl_data   <= usr_readdata;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign usr_write      = (state_q == ST_WR);
    assign usr_read       = (state_q == ST_RD);
    assign usr_address    = cmd_q.addr;
    assign usr_writedata  = cmd_q.data;
    assign usr_byteenable = '1;
    assign usr_burstcount = BC_W'(1);

endmodule

// File: rtl/regbar_bridge.sv
module regbar_bridge
    import regbar_pkg::*;
#(
    parameter int unsigned NUM_PF = 4,
    parameter int unsigned NUM_VF = 8,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned BC_W   = 4,
    parameter int unsigned TAG_W  = 6
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic                                              req_valid,
    output logic                                              req_ready,
    input  logic                                              req_write,
    input  logic [2:0]                                        req_bar,
    input  logic                                              req_vf_active,
    input  logic [$clog2(NUM_PF)-1:0]                         req_pf,
    input  logic [$clog2(NUM_VF)-1:0]                         req_vf,
    input  logic [OFS_W-1:0]                                  req_addr,
    input  logic [LEN_W-1:0]                                  req_len,
    input  logic [BC_W-1:0]                                   req_beats,
    input  logic [63:0]                                       req_wdata,
    input  logic [TAG_W-1:0]                                  req_tag,
    output logic                                              usr_read,
    output logic                                              usr_write,
    output logic [$clog2(NUM_PF)+$clog2(NUM_VF)+OFS_W:0]      usr_address,
    output logic [63:0]                                       usr_writedata,
    output logic [7:0]                                        usr_byteenable,
    output logic [BC_W-1:0]                                   usr_burstcount,
    input  logic                                              usr_waitrequest,
    input  logic [63:0]                                       usr_readdata,
    input  logic                                              usr_readdatavalid,
    output logic                                              cpl_valid,
    output logic [TAG_W-1:0]                                  cpl_tag,
    output logic [2:0]                                        cpl_status,
    output logic [63:0]                                       cpl_data,
    output logic                                              wr_err
);

    localparam int unsigned PF_W = $clog2(NUM_PF);
    localparam int unsigned VF_W = $clog2(NUM_VF);
    localparam int unsigned UA_W = 1 + PF_W + VF_W + OFS_W;

    req_class_e      cls;
    logic [UA_W-1:0] uaddr;

    regbar_screen #(
        .NUM_PF (NUM_PF),
        .NUM_VF (NUM_VF),
        .OFS_W  (OFS_W),
        .LEN_W  (LEN_W),
        .BC_W   (BC_W)
    ) i_screen (
        .bar       (req_bar),
        .vf_active (req_vf_active),
        .pf        (req_pf),
        .vf        (req_vf),
        .offset    (req_addr),
        .len       (req_len),
        .beats     (req_beats),
        .cls       (cls),
        .uaddr     (uaddr)
    );

    regbar_ctrl #(
        .UA_W  (UA_W),
        .TAG_W (TAG_W),
        .BC_W  (BC_W)
    ) i_ctrl (
        .clk               (clk),
        .rst               (rst),
        .req_valid         (req_valid),
        .req_ready         (req_ready),
        .req_write         (req_write),
        .cls               (cls),
        .uaddr             (uaddr),
        .wdata             (req_wdata),
        .tag               (req_tag),
        .usr_read          (usr_read),
        .usr_write         (usr_write),
        .usr_address       (usr_address),
        .usr_writedata     (usr_writedata),
        .usr_byteenable    (usr_byteenable),
        .usr_burstcount    (usr_burstcount),
        .usr_waitrequest   (usr_waitrequest),
        .usr_readdata      (usr_readdata),
        .usr_readdatavalid (usr_readdatavalid),
        .cpl_valid         (cpl_valid),
        .cpl_tag           (cpl_tag),
        .cpl_status        (cpl_status),
        .cpl_data          (cpl_data),
        .wr_err            (wr_err)
    );

endmodule

// File: rtl/regbar_bridge_chk.sv
module regbar_bridge_chk #(
    parameter int unsigned UA_W = 18
) (
    input logic            clk,
    input logic            rst,
    input logic            req_ready,
    input logic            usr_read,
    input logic            usr_write,
    input logic [UA_W-1:0] usr_address,
    input logic [63:0]     usr_writedata,
    input logic            usr_waitrequest,
    input logic            usr_readdatavalid,
    input logic            cpl_valid,
    input logic [2:0]      cpl_status,
    input logic            wr_err
);

    // R4: one command kind at a time
    a_r4_one_cmd: assert property (@(posedge clk) disable iff (rst)
        !(usr_read && usr_write));

    // R5: only word-aligned offsets are issued
    a_r5_aligned: assert property (@(posedge clk) disable iff (rst)
        (usr_read || usr_write) |-> (usr_address[2:0] == 3'b000));

    // R7: a write error never coincides with a completion
    a_r7_no_cpl: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> !cpl_valid);

    // R8: held read under stall
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (usr_read && usr_waitrequest) |=> (usr_read && $stable(usr_address)));

    // R8: held write under stall
    a_r8_wr_hold: assert property (@(posedge clk) disable iff (rst)
        (usr_write && usr_waitrequest) |=>
            (usr_write && $stable(usr_address) && $stable(usr_writedata)));

    // R8: command drops once taken
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        ((usr_read || usr_write) && !usr_waitrequest) |=> (!usr_read && !usr_write));

    // R9: input stalled after a read is taken
    a_r9_stall: assert property (@(posedge clk) disable iff (rst)
        (usr_read && !usr_waitrequest) |=> !req_ready);

    // R9: returned data gives a successful completion next cycle
    a_r9_cpl: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !usr_read && !usr_write && usr_readdatavalid) |=>
            (cpl_valid && cpl_status == 3'b000));

    // R10: posted write frees the input and gives no completion
    a_r10_posted: assert property (@(posedge clk) disable iff (rst)
        (usr_write && !usr_waitrequest) |=> (req_ready && !cpl_valid));

endmodule

bind regbar_bridge regbar_bridge_chk #(
    .UA_W (UA_W)
) i_chk (
    .clk               (clk),
    .rst               (rst),
    .req_ready         (req_ready),
    .usr_read          (usr_read),
    .usr_write         (usr_write),
    .usr_address       (usr_address),
    .usr_writedata     (usr_writedata),
    .usr_waitrequest   (usr_waitrequest),
    .usr_readdatavalid (usr_readdatavalid),
    .cpl_valid         (cpl_valid),
    .cpl_status        (cpl_status),
    .wr_err            (wr_err)
);

// File: tb/test_regbar_bridge.sv
`timescale 1ns/1ps
module test_regbar_bridge;

    localparam int NUM_PF = 4;
    localparam int NUM_VF = 8;
    localparam int OFS_W  = 12;
    localparam int LEN_W  = 8;
    localparam int BC_W   = 4;
    localparam int TAG_W  = 6;
    localparam int PF_W   = $clog2(NUM_PF);
    localparam int VF_W   = $clog2(NUM_VF);
    localparam int UA_W   = 1 + PF_W + VF_W + OFS_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [2:0]        req_bar = '0;
    logic              req_vf_active = 1'b0;
    logic [PF_W-1:0]   req_pf = '0;
    logic [VF_W-1:0]   req_vf = '0;
    logic [OFS_W-1:0]  req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [BC_W-1:0]   req_beats = '0;
    logic [63:0]       req_wdata = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              usr_read;
    logic              usr_write;
    logic [UA_W-1:0]   usr_address;
    logic [63:0]       usr_writedata;
    logic [7:0]        usr_byteenable;
    logic [BC_W-1:0]   usr_burstcount;
    logic              usr_waitrequest = 1'b1;
    logic [63:0]       usr_readdata = '0;
    logic              usr_readdatavalid = 1'b0;
    logic              cpl_valid;
    logic [TAG_W-1:0]  cpl_tag;
    logic [2:0]        cpl_status;
    logic [63:0]       cpl_data;
    logic              wr_err;

    int errors = 0;
    int checks = 0;

    // model slave state
    int              s_wr_cnt = 0;
    int              s_rd_cnt = 0;
    int              s_acc = 0;
    int              s_stall = 0;
    int              s_rd_delay = -1;
    logic [UA_W-1:0] s_addr = '0;
    logic [63:0]     s_data = '0;
    logic [7:0]      s_be = '0;
    logic [BC_W-1:0] s_bc = '0;
    logic [UA_W-1:0] s_rd_addr = '0;

    // completion monitor state
    int              m_cpl = 0;
    int              m_err = 0;
    logic [TAG_W-1:0] m_tag = '0;
    logic [2:0]      m_stat = '0;
    logic [63:0]     m_data = '0;

    always #5 clk = ~clk;

    regbar_bridge #(
        .NUM_PF (NUM_PF), .NUM_VF (NUM_VF), .OFS_W (OFS_W),
        .LEN_W (LEN_W), .BC_W (BC_W), .TAG_W (TAG_W)
    ) i_regbar_bridge (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_bar (req_bar), .req_vf_active (req_vf_active), .req_pf (req_pf),
        .req_vf (req_vf), .req_addr (req_addr), .req_len (req_len),
        .req_beats (req_beats), .req_wdata (req_wdata), .req_tag (req_tag),
        .usr_read (usr_read), .usr_write (usr_write), .usr_address (usr_address),
        .usr_writedata (usr_writedata), .usr_byteenable (usr_byteenable),
        .usr_burstcount (usr_burstcount), .usr_waitrequest (usr_waitrequest),
        .usr_readdata (usr_readdata), .usr_readdatavalid (usr_readdatavalid),
        .cpl_valid (cpl_valid), .cpl_tag (cpl_tag), .cpl_status (cpl_status),
        .cpl_data (cpl_data), .wr_err (wr_err)
    );

    function automatic logic [63:0] pattern(input logic [UA_W-1:0] a);
        return 64'hC3A5_0000_0000_0000 + {{(64-UA_W){1'b0}}, a} * 64'd65537;
    endfunction

    function automatic logic [UA_W-1:0] exp_addr(input int vfa, input int pf,
                                                 input int vf, input int off);
        int v;
        v = vfa * (1 << (UA_W - 1)) + pf * (1 << (VF_W + OFS_W))
          + (vfa != 0 ? vf : 0) * (1 << OFS_W) + off;
        return UA_W'(v);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // model slave: stalls acc%4 cycles, returns data acc%3 cycles after taking a read
    initial begin
        forever begin
            @(negedge clk);
            usr_readdatavalid = 1'b0;
            if (s_rd_delay > 0) begin
                s_rd_delay--;
            end else if (s_rd_delay == 0) begin
                usr_readdatavalid = 1'b1;
                usr_readdata = pattern(s_rd_addr);
                s_rd_delay = -1;
            end
            if (rst) begin
                usr_waitrequest = 1'b1;
            end else if (usr_read || usr_write) begin
                if (s_stall < (s_acc % 4)) begin
                    usr_waitrequest = 1'b1;
                    s_stall++;
                end else begin
                    usr_waitrequest = 1'b0;
                    s_stall = 0;
                    s_addr = usr_address;
                    s_data = usr_writedata;
                    s_be = usr_byteenable;
                    s_bc = usr_burstcount;
                    if (usr_write) begin
                        s_wr_cnt++;
                    end else begin
                        s_rd_cnt++;
                        s_rd_addr = usr_address;
                        s_rd_delay = s_acc % 3;
                    end
                    s_acc++;
                end
            end else begin
                usr_waitrequest = 1'b1;
            end
        end
    end

    // completion and error monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cpl_valid) begin
                m_cpl++;
                m_tag = cpl_tag;
                m_stat = cpl_status;
                m_data = cpl_data;
            end
            if (!rst && wr_err) m_err++;
        end
    end

    // returns 1 if req_ready was low in the cycle after the request was taken
    task automatic send(input bit wr, input int bar, input int vfa, input int pf,
                        input int vf, input int off, input int len, input int beats,
                        input logic [63:0] wd, input int tag, output bit busy_after);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_bar = 3'(bar);
        req_vf_active = 1'(vfa);
        req_pf = PF_W'(pf);
        req_vf = VF_W'(vf);
        req_addr = OFS_W'(off);
        req_len = LEN_W'(len);
        req_beats = BC_W'(beats);
        req_wdata = wd;
        req_tag = TAG_W'(tag);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_after = !req_ready;
        while (!req_ready) @(negedge clk);
        settle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_up();
    end

    initial begin
        int tag;
        bit busy;
        int wr0, rd0, cpl0, err0;
        logic [UA_W-1:0] ea;
        logic [63:0] wd;
        tag = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle(1);
        // R11: reset state
        check("R11 ready", req_ready, 1);
        check("R11 read", usr_read, 0);
        check("R11 write", usr_write, 0);
        check("R11 cpl", cpl_valid, 0);
        check("R11 err", wr_err, 0);

        // sweep over function identities: write then read back
        for (int pf = 0; pf < NUM_PF; pf++) begin
            for (int vfa = 0; vfa < 2; vfa++) begin
                for (int vf = 0; vf < NUM_VF; vf++) begin
                    int off;
                    off = ((pf * NUM_VF + vf) * 8 + vfa * 1024) % (1 << OFS_W);
                    ea = exp_addr(vfa, pf, vf, off);
                    wd = 64'h0123_4567_0000_0000 + 64'(pf * 256 + vfa * 16 + vf);
                    wr0 = s_wr_cnt; cpl0 = m_cpl;
                    send(1'b1, 2, vfa, pf, vf, off, 8, 1, wd, tag, busy);
                    // R2, R3: packed address, vf zeroed for a physical function
                    check(vfa != 0 ? "R2 write address" : "R3 write address pf", s_addr, ea);
                    check("R4 write data", s_data, wd);
                    check("R4 byteenable", s_be, 8'hFF);
                    check("R4 burstcount", s_bc, 1);
                    check("R10 one write", s_wr_cnt, wr0 + 1);
                    check("R10 no completion", m_cpl, cpl0);
                    tag = (tag + 1) % 64;

                    rd0 = s_rd_cnt; cpl0 = m_cpl;
                    send(1'b0, 2, vfa, pf, vf, off, 8, 1, 64'hFFFF, tag, busy);
                    check("R9 stall after read", busy, 1);
                    check("R2 read address", s_addr, ea);
                    check("R4 read burstcount", s_bc, 1);
                    check("R9 one read", s_rd_cnt, rd0 + 1);
                    check("R9 completion count", m_cpl, cpl0 + 1);
                    check("R9 completion tag", m_tag, tag);
                    check("R9 completion status", m_stat, 3'b000);
                    check("R9 completion data", m_data, pattern(ea));
                    tag = (tag + 1) % 64;
                end
            end
        end

        // R5/R6/R7: each qualification term broken on its own
        for (int k = 0; k < 12; k++) begin
            int off, len, beats;
            off = 64; len = 8; beats = 1;
            if (k < 7) off = 64 + k + 1;
            else if (k == 7) len = 0;
            else if (k == 8) len = 4;
            else if (k == 9) len = 16;
            else if (k == 10) beats = 0;
            else beats = 2;
            for (int wr = 0; wr < 2; wr++) begin
                wr0 = s_wr_cnt; rd0 = s_rd_cnt; cpl0 = m_cpl; err0 = m_err;
                send(wr[0], 2, 1, 1, 5, off, len, beats, 64'hDEAD, tag, busy);
                check("R5 no write issued", s_wr_cnt, wr0);
                check("R5 no read issued", s_rd_cnt, rd0);
                if (wr != 0) begin
                    check("R7 error pulse", m_err, err0 + 1);
                    check("R7 no completion", m_cpl, cpl0);
                end else begin
                    check("R6 completion count", m_cpl, cpl0 + 1);
                    check("R6 status UR", m_stat, 3'b001);
                    check("R6 tag", m_tag, tag);
                    check("R6 data zero", m_data, 0);
                    check("R6 no error pulse", m_err, err0);
                end
                tag = (tag + 1) % 64;
            end
        end

        // R1: other region indices are consumed silently
        for (int bar = 0; bar < 8; bar++) begin
            if (bar == 2) continue;
            for (int wr = 0; wr < 2; wr++) begin
                wr0 = s_wr_cnt; rd0 = s_rd_cnt; cpl0 = m_cpl; err0 = m_err;
                send(wr[0], bar, 0, 2, 0, 128, 8, 1, 64'hBEEF, tag, busy);
                check("R1 no write", s_wr_cnt, wr0);
                check("R1 no read", s_rd_cnt, rd0);
                check("R1 no completion", m_cpl, cpl0);
                check("R1 no error", m_err, err0);
                check("R1 ready again", req_ready, 1);
                tag = (tag + 1) % 64;
            end
        end

        // R8: a request after a misaligned burst of traffic still lands on the expected address
        ea = exp_addr(1, 3, 7, 4088);
        send(1'b0, 2, 1, 3, 7, 4088, 8, 1, 64'h0, 9, busy);
        check("R8 top offset address", s_addr, ea);
        check("R8 top offset data", m_data, pattern(ea));

        finish_up();
    end

endmodule